// File: doc/BRIEF.md
# Configuration Load Sequencer

This block brings a device from power-up, or from a program request, to a running state by loading a configuration image into an internal frame store. Each start clears the whole store and then samples two mode pins. The pins choose whether the block drives the configuration clock or receives it from outside, and whether data arrives one bit at a time or on a byte-wide port. On the byte-wide port, a marker transfer at the head of the stream tells the block whether 8 or 16 pins carry data.

After the width marker, the block hunts for a fixed 32-bit synchronisation pattern. It then checks a device identifier word and writes a fixed number of frame words into the store. Finally it compares a running CRC-32 against the last word of the stream. When every check passes, a staged startup follows: the internal design reset is released, the block waits for clock lock if asked to, outputs are enabled, and the done flag rises. A wrong identifier or a wrong CRC parks the block in an error state that keeps the design in reset until the next program request.

Top module: `cfgload_seq`

## Requirements
- R1: While `rst_n` (synchronous) or `prog_n` is low, `core_rst_n`, `io_en`, `done` and `err` are low from the next clock edge on. Releasing `prog_n` starts a new load from the beginning.
- R2: At every start, all DEPTH frame words are written to zero before any stream data is accepted. After a new start, every word read through `mem_rd_addr`/`mem_rd_data` is 0.
- R3: The mode pins are sampled after the clear. `mode_pins[0]`=1 selects master and `mode_pins[1]`=1 selects byte-wide.
  - In master mode the block toggles `cfg_clk_out` and takes data on its rising edge.
  - In slave mode `cfg_clk_out` stays low and data is taken on each rising edge of `cfg_clk_in`.
- R4: In byte-wide mode, transfers are ignored until one arrives whose low byte `cfg_din[7:0]` is 0xBB. If its upper byte `cfg_din[15:8]` is 0x99, 16-bit transfers follow; otherwise 8-bit transfers follow on `cfg_din[7:0]`.
- R5: Words are 32 bits and are assembled most-significant part first. Serial mode uses `cfg_din[0]`, 32 bits per word. The 8-bit mode uses 4 bytes per word and the 16-bit mode uses 2 halves per word.
- R6: The sync pattern 0xAA995566 is found at any bit offset in serial mode. In byte-wide mode it is found only on word boundaries counted from the transfer after the width marker. Words that are not the pattern are ignored.
- R7: The first word after sync must equal the DEV_ID parameter; otherwise the error state is entered.
- R8: The next DEPTH words are stored at addresses 0 to DEPTH-1 in arrival order.
- R9: The word after the frames must equal a CRC-32 over the identifier and frame words, otherwise the error state is entered. The CRC uses polynomial 0x04C11DB7, initial value 0xFFFFFFFF, most-significant bit first, no reflection and no final inversion.
- R10: After a passing CRC word, `core_rst_n` rises first. `io_en` rises no earlier than one cycle later, and exactly one cycle later when no lock wait applies. `done` rises one cycle after `io_en`. All three then stay high until a program request.
- R11: If `lock_wait_en` was high when the mode pins were sampled, `io_en` and `done` stay low after the reset release until `clk_locked` is high.
- R12: In the error state `err` is high and `done`, `io_en`, `core_rst_n` are low. This holds until `prog_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| prog_n | input | 1 | Active-low program request |
| mode_pins | input | 2 | Bit 0 master, bit 1 byte-wide |
| lock_wait_en | input | 1 | Startup waits for clock lock when set at mode sampling |
| clk_locked | input | 1 | Clock generators locked |
| cfg_clk_in | input | 1 | External configuration clock (slave modes) |
| cfg_clk_out | output | 1 | Configuration clock driven in master modes |
| cfg_din | input | 16 | Configuration data (bit 0 in serial mode) |
| mem_rd_addr | input | AW | Frame store read address |
| mem_rd_data | output | 32 | Frame store read data |
| core_rst_n | output | 1 | Internal design reset release (high = released) |
| io_en | output | 1 | Output drivers enabled |
| done | output | 1 | Configuration complete |
| err | output | 1 | Identifier or CRC failure |

## Verification
The bound checker watches the startup outputs on every cycle. It confirms that `done` never appears without `io_en` and a released reset, and that `io_en` only rises after the reset release. It also confirms that `done` and `err` hold until a program request, that the error state keeps the design in reset, and that a program request drops every output at the next edge. The directed scenarios are the only place where the stream itself is shown to be handled. They cover the CRC value, the width marker choice, sync found at an odd bit offset, frame storage order, clearing of the store, the lock wait, and the clock behaviour in master versus slave mode.

// File: rtl/cfgload_pkg.sv
// Shared definitions for the configuration load sequencer: state
// encoding, stream marker constants and the word-wide CRC-32 step.
package cfgload_pkg;

    typedef enum logic [3:0] {
        ST_HOLD,
        ST_CLEAR,
        ST_MODE,
        ST_WIDTH,
        ST_SYNC,
        ST_ID,
        ST_LOAD,
        ST_CRC,
        ST_LOCK,
        ST_IOEN,
        ST_DONE,
        ST_ERR
    } cfg_state_t;

    localparam logic [31:0] SYNC_PATTERN = 32'hAA99_5566;
    localparam logic [7:0]  WIDTH_MARK   = 8'hBB;
    localparam logic [7:0]  WIDE_TAG     = 8'h99;
    localparam logic [31:0] CRC_POLY     = 32'h04C1_1DB7;

    // Advance a CRC-32 register over one 32-bit word, MSB first.
    function automatic logic [31:0] crc32_step(input logic [31:0] acc,
                                               input logic [31:0] data);
        logic [31:0] c;
        logic        fb;
        c = acc;
        for (int i = 31; i >= 0; i--) begin
            fb = c[31] ^ data[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/cfgload_clkgen.sv
// Configuration clock front end.
// Master: divides clk to produce cfg clock, strobe on its rising edge.
// Slave: synchronises the external clock, strobe on its rising edge.
// Assumes the external clock is much slower than clk (>= 4 clk per phase)
// and CCLK_DIV >= 1, so strobes are at least two cycles apart.
module cfgload_clkgen #(
    parameter int unsigned CCLK_DIV = 2,
    localparam int unsigned CW = (CCLK_DIV > 1) ? $clog2(CCLK_DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic master,
    input  logic ext_clk,
    output logic cclk_out,
    output logic strobe
);
    localparam logic [CW-1:0] DIV_LAST = CW'(CCLK_DIV - 1);

    logic [CW-1:0] div_cnt;
    logic          cclk_q;
    logic [2:0]    ext_sync;
    logic          div_wrap;

    assign div_wrap = (div_cnt == DIV_LAST);

    // Divider and output clock toggle for master mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            cclk_q  <= 1'b0;
        end else if (!en || !master) begin
            div_cnt <= '0;
            cclk_q  <= 1'b0;
        end else if (div_wrap) begin
            div_cnt <= '0;
            cclk_q  <= ~cclk_q;
        end else begin
            div_cnt <= div_cnt + CW'(1);
        end
    end

    // Two-flop synchroniser plus edge history for the slave clock.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sync <= '0;
        else        ext_sync <= {ext_sync[1:0], ext_clk};
    end

    // Strobe: the sample point of one data transfer.
    always_comb begin
        if (!en)         strobe = 1'b0;
        else if (master) strobe = div_wrap && !cclk_q;
        else             strobe = ext_sync[1] && !ext_sync[2];
    end

    assign cclk_out = cclk_q;

endmodule

// File: rtl/cfgload_wordasm.sv
// Assembles transfers into 32-bit words, first transfer most significant.
// Serial: bit 0 of din, 32 per word. Byte-wide: 8 bits x4 or 16 bits x2.
// unit_vld pulses the cycle after each strobe with the shifted window in
// win; word_vld pulses on the same cycle when a word boundary is reached.
// restart realigns the boundary; it never coincides with a strobe.
module cfgload_wordasm (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strobe,
    input  logic [15:0] din,
    input  logic        par,
    input  logic        wide,
    input  logic        restart,
    output logic [31:0] win,
    output logic        unit_vld,
    output logic        word_vld
);
    logic [4:0]  unit_cnt;
    logic [4:0]  last_unit;
    logic [31:0] shifted;

    // Transfers per word minus one, and the shifted window for each width.
    always_comb begin
        if (!par) begin
            last_unit = 5'd31;
            shifted   = {win[30:0], din[0]};
        end else if (!wide) begin
            last_unit = 5'd3;
            shifted   = {win[23:0], din[7:0]};
        end else begin
            last_unit = 5'd1;
            shifted   = {win[15:0], din};
        end
    end

    // Shift window, transfer counter and valid pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win      <= '0;
            unit_cnt <= '0;
            unit_vld <= 1'b0;
            word_vld <= 1'b0;
        end else begin
            unit_vld <= strobe;
            word_vld <= 1'b0;
            if (restart) begin
                unit_cnt <= '0;
            end else if (strobe) begin
                win <= shifted;
                if (unit_cnt >= last_unit) begin
                    unit_cnt <= '0;
                    word_vld <= 1'b1;
                end else begin
                    unit_cnt <= unit_cnt + 5'd1;
                end
            end
        end
    end

endmodule

// File: rtl/cfgload_crc.sv
// Running CRC-32 accumulator: init loads all ones, upd folds in one word.
module cfgload_crc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        upd,
    input  logic [31:0] data,
    output logic [31:0] acc
);
    import cfgload_pkg::*;

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc <= '1;
        else if (init) acc <= '1;
        else if (upd)  acc <= crc32_step(acc, data);
    end

endmodule

// File: rtl/cfgload_fmem.sv
// Frame store model: one synchronous write port, one asynchronous read
// port. Contents are not reset; the sequencer clears them on every start.
module cfgload_fmem #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned AW    = 3
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data
);
    logic [31:0] store [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    assign rd_data = store[rd_addr];

endmodule

// File: rtl/cfgload_seq.sv
// Configuration load sequencer top.
// Flow: hold -> clear store -> sample mode -> width marker (byte-wide)
// -> sync hunt -> device ID -> DEPTH frame words -> CRC word -> staged
// startup (reset release, optional lock wait, output enable, done).
// Assumes DEPTH >= 1 and CCLK_DIV >= 1; mode pins stay stable during a load.
module cfgload_seq #(
    parameter int unsigned DEPTH    = 8,
    parameter logic [31:0] DEV_ID   = 32'h1D5E_0A37,
    parameter int unsigned CCLK_DIV = 2,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_n,
    input  logic [1:0]    mode_pins,
    input  logic          lock_wait_en,
    input  logic          clk_locked,
    input  logic          cfg_clk_in,
    output logic          cfg_clk_out,
    input  logic [15:0]   cfg_din,
    input  logic [AW-1:0] mem_rd_addr,
    output logic [31:0]   mem_rd_data,
    output logic          core_rst_n,
    output logic          io_en,
    output logic          done,
    output logic          err
);
    import cfgload_pkg::*;

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    cfg_state_t    st, st_nx;
    logic [AW-1:0] idx;
    logic          is_master, is_par, wide, wait_lock;
    logic          strobe, unit_vld, word_vld;
    logic [31:0]   win, crc_acc, mem_wd;
    logic          restart, crc_init, crc_upd, mem_we;
    logic          gen_en, sync_hit;

    assign gen_en = (st == ST_WIDTH) || (st == ST_SYNC) || (st == ST_ID) ||
                    (st == ST_LOAD)  || (st == ST_CRC);

    // Serial hunts on every bit, byte-wide only on word boundaries.
    assign sync_hit = (win == SYNC_PATTERN) && (is_par ? word_vld : unit_vld);

    cfgload_clkgen #(.CCLK_DIV(CCLK_DIV)) clkgen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (gen_en),
        .master   (is_master),
        .ext_clk  (cfg_clk_in),
        .cclk_out (cfg_clk_out),
        .strobe   (strobe)
    );

    cfgload_wordasm wordasm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (strobe),
        .din      (cfg_din),
        .par      (is_par),
        .wide     (wide),
        .restart  (restart),
        .win      (win),
        .unit_vld (unit_vld),
        .word_vld (word_vld)
    );

    cfgload_crc crc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .upd   (crc_upd),
        .data  (win),
        .acc   (crc_acc)
    );

    cfgload_fmem #(.DEPTH(DEPTH), .AW(AW)) fmem_i (
        .clk     (clk),
        .wr_en   (mem_we),
        .wr_addr (idx),
        .wr_data (mem_wd),
        .rd_addr (mem_rd_addr),
        .rd_data (mem_rd_data)
    );

    // Next-state and per-cycle control decode.
    always_comb begin
        st_nx    = st;
        restart  = 1'b0;
        crc_init = 1'b0;
        crc_upd  = 1'b0;
        mem_we   = 1'b0;
        mem_wd   = '0;
        case (st)
            ST_HOLD:  st_nx = ST_CLEAR;
            ST_CLEAR: begin
                mem_we = 1'b1;
                if (idx == LAST_IDX) st_nx = ST_MODE;
            end
            ST_MODE: begin
                restart = 1'b1;
                st_nx   = mode_pins[1] ? ST_WIDTH : ST_SYNC;
            end
            ST_WIDTH: begin
                if (unit_vld && (win[7:0] == WIDTH_MARK)) begin
                    restart = 1'b1;
                    st_nx   = ST_SYNC;
                end
            end
            ST_SYNC: begin
                if (sync_hit) begin
                    restart  = 1'b1;
                    crc_init = 1'b1;
                    st_nx    = ST_ID;
                end
            end
            ST_ID: begin
                if (word_vld) begin
                    crc_upd = 1'b1;
                    st_nx   = (win == DEV_ID) ? ST_LOAD : ST_ERR;
                end
            end
            ST_LOAD: begin
                if (word_vld) begin
                    mem_we  = 1'b1;
                    mem_wd  = win;
                    crc_upd = 1'b1;
                    if (idx == LAST_IDX) st_nx = ST_CRC;
                end
            end
            ST_CRC: begin
                if (word_vld) st_nx = (win == crc_acc) ? ST_LOCK : ST_ERR;
            end
            ST_LOCK:  if (!wait_lock || clk_locked) st_nx = ST_IOEN;
            ST_IOEN:  st_nx = ST_DONE;
            ST_DONE:  st_nx = ST_DONE;
            ST_ERR:   st_nx = ST_ERR;
            default:  st_nx = ST_HOLD;
        endcase
        if (!prog_n) begin
            st_nx  = ST_HOLD;
            mem_we = 1'b0;
        end
    end

    // State register and registered startup outputs decoded from next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_HOLD;
            core_rst_n <= 1'b0;
            io_en      <= 1'b0;
            done       <= 1'b0;
            err        <= 1'b0;
        end else begin
            st         <= st_nx;
            core_rst_n <= (st_nx == ST_LOCK) || (st_nx == ST_IOEN) ||
                          (st_nx == ST_DONE);
            io_en      <= (st_nx == ST_IOEN) || (st_nx == ST_DONE);
            done       <= (st_nx == ST_DONE);
            err        <= (st_nx == ST_ERR);
        end
    end

    // Store index, latched mode settings and detected bus width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            is_master <= 1'b0;
            is_par    <= 1'b0;
            wide      <= 1'b1;
            wait_lock <= 1'b0;
        end else begin
            if (st == ST_HOLD || st == ST_ID)
                idx <= '0;
            else if (mem_we)
                idx <= (idx == LAST_IDX) ? '0 : idx + AW'(1);
            if (st == ST_MODE) begin
                is_master <= mode_pins[0];
                is_par    <= mode_pins[1];
                wait_lock <= lock_wait_en;
                wide      <= 1'b1;
            end else if (st == ST_WIDTH && st_nx == ST_SYNC) begin
                wide <= (win[15:8] == WIDE_TAG);
            end
        end
    end

endmodule

// File: rtl/cfgload_seq_chk.sv
// Cycle-level checks on the startup and abort outputs of the sequencer.
module cfgload_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic prog_n,
    input logic core_rst_n,
    input logic io_en,
    input logic done,
    input logic err
);
    AST_DONE_NEEDS_IOEN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (io_en && core_rst_n)); // R10
    AST_IOEN_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_en) |-> $past(core_rst_n)); // R10
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && prog_n) |=> done); // R10
    AST_ERR_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!done && !io_en && !core_rst_n)); // R12
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && prog_n) |=> err); // R12
    AST_PROG_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |=> (!done && !err && !io_en && !core_rst_n)); // R1
endmodule

bind cfgload_seq cfgload_seq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_n     (prog_n),
    .core_rst_n (core_rst_n),
    .io_en      (io_en),
    .done       (done),
    .err        (err)
);

// File: tb/cfgload_seq_tb_top.sv
// Directed bench for the configuration load sequencer.
module cfgload_seq_tb_top;

    localparam int          DEPTH = 8;
    localparam int          AW    = 3;
    localparam logic [31:0] ID    = 32'h1D5E_0A37;
    localparam logic [31:0] SYNCW = 32'hAA99_5566;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_n = 1'b1;
    logic [1:0]    mode_pins = 2'b00;
    logic          lock_wait_en = 1'b0;
    logic          clk_locked = 1'b0;
    logic          cfg_clk_in = 1'b0;
    logic          cfg_clk_out;
    logic [15:0]   cfg_din = '0;
    logic [AW-1:0] mem_rd_addr = '0;
    logic [31:0]   mem_rd_data;
    logic          core_rst_n, io_en, done, err;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int t_rst = -1, t_io = -1, t_done = -1;
    bit cclk_seen = 1'b0;
    bit tb_wide = 1'b0;
    logic [31:0] frames [DEPTH];

    cfgload_seq #(.DEPTH(DEPTH), .DEV_ID(ID), .CCLK_DIV(2)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .prog_n       (prog_n),
        .mode_pins    (mode_pins),
        .lock_wait_en (lock_wait_en),
        .clk_locked   (clk_locked),
        .cfg_clk_in   (cfg_clk_in),
        .cfg_clk_out  (cfg_clk_out),
        .cfg_din      (cfg_din),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_data  (mem_rd_data),
        .core_rst_n   (core_rst_n),
        .io_en        (io_en),
        .done         (done),
        .err          (err)
    );

    always #5 clk = ~clk;

    // Records the cycle each startup output is first seen high.
    always @(negedge clk) begin
        cyc++;
        if (core_rst_n && t_rst < 0) t_rst = cyc;
        if (io_en && t_io < 0)       t_io = cyc;
        if (done && t_done < 0)      t_done = cyc;
        if (cfg_clk_out)             cclk_seen = 1'b1;
    end

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] tb_crc(input logic [31:0] c_in,
                                           input logic [31:0] w);
        logic [31:0] c;
        c = c_in;
        for (int b = 31; b >= 0; b--) begin
            if (c[31] ^ w[b]) c = (c << 1) ^ 32'h04C1_1DB7;
            else              c = c << 1;
        end
        return c;
    endfunction

    task automatic send_unit(input logic [15:0] v);
        cfg_din = v;
        if (mode_pins[0]) begin
            @(posedge cfg_clk_out);
            #1;
        end else begin
            #20 cfg_clk_in = 1'b1;
            #40 cfg_clk_in = 1'b0;
            #40;
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        if (!mode_pins[1]) begin
            for (int i = 31; i >= 0; i--) send_unit({15'b0, w[i]});
        end else if (!tb_wide) begin
            for (int i = 3; i >= 0; i--) send_unit({8'h00, w[i*8 +: 8]});
        end else begin
            send_unit(w[31:16]);
            send_unit(w[15:0]);
        end
    endtask

    task automatic fill(input logic [31:0] seed);
        for (int i = 0; i < DEPTH; i++)
            frames[i] = (seed * 32'h0101_0101) ^ (32'h00C0_0000 + i * 32'h1357_9BDF);
    endtask

    task automatic send_stream(input logic [31:0] id, input logic [31:0] flip);
        logic [31:0] c;
        send_word(SYNCW);
        send_word(id);
        c = tb_crc(32'hFFFF_FFFF, id);
        for (int i = 0; i < DEPTH; i++) begin
            send_word(frames[i]);
            c = tb_crc(c, frames[i]);
        end
        send_word(c ^ flip);
    endtask

    task automatic start_load(input logic [1:0] m, input logic lw);
        mode_pins    = m;
        lock_wait_en = lw;
        prog_n       = 1'b0;
        repeat (4) @(negedge clk);
        t_rst = -1; t_io = -1; t_done = -1; cclk_seen = 1'b0;
        prog_n = 1'b1;
        repeat (DEPTH + 6) @(negedge clk);
    endtask

    task automatic check_mem(input string tag);
        for (int i = 0; i < DEPTH; i++) begin
            mem_rd_addr = AW'(i);
            #1;
            check(mem_rd_data == frames[i], tag, mem_rd_data, frames[i]);
        end
    endtask

    task automatic check_mem_zero(input string tag);
        for (int i = 0; i < DEPTH; i++) begin
            mem_rd_addr = AW'(i);
            #1;
            check(mem_rd_data == 32'h0, tag, mem_rd_data, 32'h0);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check({core_rst_n, io_en, done, err} == 4'b0, "R1 outputs in reset",
              {core_rst_n, io_en, done, err}, 0);
        rst_n = 1'b1;
        repeat (DEPTH + 10) @(negedge clk);
        check({core_rst_n, io_en, done, err} == 4'b0, "R1 outputs idle after reset",
              {core_rst_n, io_en, done, err}, 0);
        check_mem_zero("R2 store cleared after power-up");
    endtask

    task automatic t_serial_slave;
        start_load(2'b00, 1'b0);
        fill(32'h11);
        // Five stray bits put the sync pattern at an odd bit offset.
        send_unit(16'h1); send_unit(16'h0); send_unit(16'h1);
        send_unit(16'h1); send_unit(16'h0);
        send_stream(ID, 32'h0);
        repeat (12) @(negedge clk);
        check(done == 1'b1, "R9 serial load done", done, 1);
        check(err == 1'b0, "R6 serial sync at odd offset no error", err, 0);
        check(t_io == t_rst + 1, "R10 io_en one cycle after release", t_io, t_rst + 1);
        check(t_done == t_io + 1, "R10 done one cycle after io_en", t_done, t_io + 1);
        check(cclk_seen == 1'b0, "R3 slave leaves cfg_clk_out low", cclk_seen, 0);
        check_mem("R5 R8 serial frame word");
    endtask

    task automatic t_par8_master_lock;
        clk_locked = 1'b0;
        tb_wide    = 1'b0;
        start_load(2'b11, 1'b1);
        fill(32'h22);
        send_unit(16'h0012);          // ignored before the width marker (R4)
        send_unit(16'h00BB);          // width marker, 8-bit
        send_word(32'h1234_5678);     // aligned non-sync word ignored (R6)
        send_stream(ID, 32'h0);
        repeat (30) @(negedge clk);
        check(core_rst_n == 1'b1, "R11 reset released while waiting for lock", core_rst_n, 1);
        check(io_en == 1'b0, "R11 io_en held until lock", io_en, 0);
        check(done == 1'b0, "R11 done held until lock", done, 0);
        clk_locked = 1'b1;
        repeat (5) @(negedge clk);
        check(done == 1'b1, "R11 done after lock", done, 1);
        check(t_done == t_io + 1, "R10 done follows io_en", t_done, t_io + 1);
        check(cclk_seen == 1'b1, "R3 master drives cfg_clk_out", cclk_seen, 1);
        check_mem("R4 R8 8-bit frame word");
    endtask

    task automatic t_par16_slave_prog;
        tb_wide = 1'b1;
        start_load(2'b10, 1'b0);
        fill(32'h33);
        send_unit(16'h99BB);          // width marker, 16-bit
        send_stream(ID, 32'h0);
        repeat (12) @(negedge clk);
        check(done == 1'b1, "R4 16-bit load done", done, 1);
        check(err == 1'b0, "R9 16-bit crc accepted", err, 0);
        check_mem("R5 R8 16-bit frame word");
        repeat (10) @(negedge clk);
        check(done == 1'b1, "R10 done stays high", done, 1);
        prog_n = 1'b0;
        repeat (2) @(negedge clk);
        check({core_rst_n, io_en, done} == 3'b0, "R1 program request drops outputs",
              {core_rst_n, io_en, done}, 0);
        prog_n = 1'b1;
        repeat (DEPTH + 6) @(negedge clk);
        check_mem_zero("R2 store cleared on program request");
    endtask

    task automatic t_bad_id;
        start_load(2'b01, 1'b0);
        send_unit(16'h0);
        send_word(SYNCW);
        send_word(ID ^ 32'h0000_0100);
        repeat (12) @(negedge clk);
        check(err == 1'b1, "R7 device id mismatch flags error", err, 1);
        check(done == 1'b0, "R12 no done after id error", done, 0);
        check(core_rst_n == 1'b0, "R12 design held in reset", core_rst_n, 0);
    endtask

    task automatic t_bad_crc;
        tb_wide = 1'b0;
        start_load(2'b10, 1'b0);
        fill(32'h44);
        send_unit(16'h00BB);
        send_stream(ID, 32'h0000_0001);
        repeat (12) @(negedge clk);
        check(err == 1'b1, "R9 crc mismatch flags error", err, 1);
        check({core_rst_n, io_en, done} == 3'b0, "R12 outputs low after crc error",
              {core_rst_n, io_en, done}, 0);
        repeat (20) @(negedge clk);
        check(err == 1'b1, "R12 error persists", err, 1);
        prog_n = 1'b0;
        repeat (2) @(negedge clk);
        check(err == 1'b0, "R1 program request clears error", err, 0);
        prog_n = 1'b1;
        repeat (DEPTH + 6) @(negedge clk);
        check_mem_zero("R2 store cleared after error");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        t_reset();
        t_serial_slave();
        t_par8_master_lock();
        t_par16_slave_prog();
        t_bad_id();
        t_bad_crc();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule